// File: doc/BRIEF.md
# Delay-Slot Resume Address Calculator

When a trap handler has to step over an instruction that faulted, it must know where execution goes next. It must also know which instruction actually raised the fault. For a branch with a delay slot, the culprit is the slot instruction at PC + 2, not the branch itself. This block takes the 16-bit instruction found at the trapping PC, together with the condition bit, the sixteen general registers and the return-address register. From these it produces the resume address, the address of the instruction to inspect, and whether the return-address register must be rewritten and with what value.

Each request is one cycle with `req_valid` high. The answer is registered and appears, with `rsp_valid`, on the cycle after. Between requests the previous answer is held. Fetching the inspected instruction and carrying it out are left to the caller.

Top module: `slot_resume_calc`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. After reset, every response output is zero.
- R2: An opcode whose bits [15:12] are 0xA (plain jump) or 0xB (call) resumes at PC + 4 + 2 × sign-extended bits [11:0].
- R3: The call form with bits [15:12] = 0xB raises `rsp_link_we` with `rsp_link_value` = PC + 4. The 0xA form leaves `rsp_link_we` low.
- R4: An opcode with bits [15:8] = 0x8D resumes at PC + 4 + 2 × sign-extended bits [7:0] when `cond_t` is 1, and at PC + 4 when it is 0.
- R5: An opcode with bits [15:8] = 0x8F resumes at the displaced target when `cond_t` is 0, and at PC + 4 when it is 1.
- R6: Bits [15:12] = 0x4, bits [3:0] = 0xB and bits [7:4] of 0 or 2 resume at the general register indexed by bits [11:8]. Only bits [7:4] = 0 raises `rsp_link_we`, with `rsp_link_value` = PC + 4.
- R7: Bits [15:12] = 0x0, bits [3:0] = 0x3 and bits [7:4] of 0 or 2 resume at PC + 4 + the general register indexed by bits [11:8]. Neither form raises `rsp_link_we`.
- R8: The opcode 0x000B resumes at the `ret_addr` input.
- R9: Every branch in R2 to R8 reports `rsp_slot` = 1 and an inspect address of PC + 2.
- R10: Every other opcode, near misses included (such as 0x8B, or nibble [7:4] = 1 in the R6/R7 patterns), resumes at PC + 2. It inspects PC, reports `rsp_slot` = 0 and keeps `rsp_link_we` low. Whenever `rsp_link_we` is low, `rsp_link_value` is 0.
- R11: In a cycle without `req_valid`, all response values keep their previous contents.
- R12: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_insn | input | 16 | Instruction at the trapping PC |
| req_pc | input | 32 | Trapping PC |
| cond_t | input | 1 | Condition bit |
| gpr_flat | input | 512 | General registers, register i in bits [32i+31:32i] |
| ret_addr | input | 32 | Current return-address register |
| rsp_valid | output | 1 | Response strobe |
| rsp_next_pc | output | 32 | Resume address |
| rsp_inspect | output | 32 | Address of the instruction to inspect |
| rsp_slot | output | 1 | Inspected instruction is a delay slot |
| rsp_link_we | output | 1 | Return-address register must be written |
| rsp_link_value | output | 32 | Value for the return-address register |

## Verification
Every one of the 65536 opcodes goes through the block, so near misses get checked as well as the intended encodings. A decoder that ignored bits [7:4] in the register-jump patterns, or mistook 0x8B for a slotted branch, would send execution to a wild address instead of PC + 2. Both polarities of the condition bit are forced on each conditional form, which catches a swapped test on 0x8D versus 0x8F. Negative displacements and sums that wrap past 2^32 expose a sign-extension or width error. A link flag raised for the register-relative call, or for the plain jump, would show up as a spurious return-address update.

// File: rtl/slot_resume_pkg.sv
package slot_resume_pkg;

    localparam int ADDR_W   = 32;
    localparam int INSN_W   = 16;
    localparam int NIB_W    = 4;
    localparam int GPR_NUM  = 16;
    localparam int GPR_IDXW = $clog2(GPR_NUM);
    localparam int LONG_DW  = 12;
    localparam int SHORT_DW = 8;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [3:0] {
        BK_NONE,
        BK_JUMP_REL,
        BK_CALL_REL,
        BK_CND_T,
        BK_CND_F,
        BK_JUMP_REG,
        BK_CALL_REG,
        BK_JUMP_OFS,
        BK_CALL_OFS,
        BK_RETURN
    } br_kind_e;

    typedef struct packed {
        logic [NIB_W-1:0] top;
        logic [NIB_W-1:0] reg_sel;
        logic [NIB_W-1:0] mid;
        logic [NIB_W-1:0] low;
    } insn_nibs_t;

    typedef struct packed {
        addr_t next_pc;
        addr_t inspect;
        logic  slot;
        logic  link_we;
        addr_t link_value;
    } resume_t;

    function automatic insn_nibs_t split_insn(input logic [INSN_W-1:0] w);
        insn_nibs_t n;
        n.top     = w[15:12];
        n.reg_sel = w[11:8];
        n.mid     = w[7:4];
        n.low     = w[3:0];
        return n;
    endfunction

    function automatic addr_t sext_x2(input logic [LONG_DW-1:0] f, input int width);
        addr_t r;
        r = '0;
        for (int i = 0; i < LONG_DW; i++) begin
            if (i < width) r[i+1] = f[i];
        end
        for (int i = 1; i < ADDR_W; i++) begin
            if (i > width) r[i] = f[width-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/resume_decode.sv
module resume_decode
    import slot_resume_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output br_kind_e          kind,
    output insn_nibs_t        nibs
);
    localparam int N_CLASSES = 9;

    logic [N_CLASSES-1:0] hit;

    always_comb begin
        nibs   = split_insn(insn);
        hit    = '0;
        hit[0] = (nibs.top == 4'hA);
        hit[1] = (nibs.top == 4'hB);
        hit[2] = (nibs.top == 4'h8) && (nibs.reg_sel == 4'hD);
        hit[3] = (nibs.top == 4'h8) && (nibs.reg_sel == 4'hF);
        hit[4] = (nibs.top == 4'h4) && (nibs.low == 4'hB) && (nibs.mid == 4'h2);
        hit[5] = (nibs.top == 4'h4) && (nibs.low == 4'hB) && (nibs.mid == 4'h0);
        hit[6] = (nibs.top == 4'h0) && (nibs.low == 4'h3) && (nibs.mid == 4'h2);
        hit[7] = (nibs.top == 4'h0) && (nibs.low == 4'h3) && (nibs.mid == 4'h0);
        hit[8] = (insn == 16'h000B);
    end

    always_comb begin
        kind = BK_NONE;
        unique casez (hit)
            9'b????????1: kind = BK_JUMP_REL;
            9'b???????10: kind = BK_CALL_REL;
            9'b??????100: kind = BK_CND_T;
            9'b?????1000: kind = BK_CND_F;
            9'b????10000: kind = BK_JUMP_REG;
            9'b???100000: kind = BK_CALL_REG;
            9'b??1000000: kind = BK_JUMP_OFS;
            9'b?10000000: kind = BK_CALL_OFS;
            9'b100000000: kind = BK_RETURN;
            default:      kind = BK_NONE;
        endcase
    end
endmodule

// File: rtl/resume_target.sv
module resume_target
    import slot_resume_pkg::*;
(
    input  br_kind_e          kind,
    input  insn_nibs_t        nibs,
    input  addr_t             pc,
    input  logic              cond_t,
    input  addr_t             reg_val,
    input  addr_t             ret_addr,
    output resume_t           res
);
    addr_t pc_seq;
    addr_t pc_slot;
    addr_t disp_long;
    addr_t disp_short;
    logic  cond_taken;

    always_comb begin
        pc_seq     = pc + addr_t'(2);
        pc_slot    = pc + addr_t'(4);
        disp_long  = sext_x2({nibs.reg_sel, nibs.mid, nibs.low}, LONG_DW);
        disp_short = sext_x2({4'h0, nibs.mid, nibs.low}, SHORT_DW);
        cond_taken = (kind == BK_CND_T) ? cond_t : !cond_t;

        res.next_pc = pc_seq;
        case (kind)
            BK_JUMP_REL, BK_CALL_REL: res.next_pc = pc_slot + disp_long;
            BK_CND_T, BK_CND_F:       res.next_pc = cond_taken ? (pc_slot + disp_short) : pc_slot;
            BK_JUMP_REG, BK_CALL_REG: res.next_pc = reg_val;
            BK_JUMP_OFS, BK_CALL_OFS: res.next_pc = pc_slot + reg_val;
            BK_RETURN:                res.next_pc = ret_addr;
            default:                  res.next_pc = pc_seq;
        endcase

        res.slot       = (kind != BK_NONE);
        res.inspect    = res.slot ? pc_seq : pc;
        res.link_we    = (kind == BK_CALL_REL) || (kind == BK_CALL_REG);
        res.link_value = res.link_we ? pc_slot : '0;
    end
endmodule

// File: rtl/resume_hold.sv
module resume_hold
    import slot_resume_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  resume_t d,
    output logic    valid,
    output resume_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else begin
            valid <= load;
            if (load) q <= d;
        end
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !load |=> !valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/slot_resume_calc.sv
module slot_resume_calc
    import slot_resume_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [INSN_W-1:0]           req_insn,
    input  logic [ADDR_W-1:0]           req_pc,
    input  logic                        cond_t,
    input  logic [GPR_NUM*ADDR_W-1:0]   gpr_flat,
    input  logic [ADDR_W-1:0]           ret_addr,
    output logic                        rsp_valid,
    output logic [ADDR_W-1:0]           rsp_next_pc,
    output logic [ADDR_W-1:0]           rsp_inspect,
    output logic                        rsp_slot,
    output logic                        rsp_link_we,
    output logic [ADDR_W-1:0]           rsp_link_value
);
    br_kind_e   kind;
    insn_nibs_t nibs;
    addr_t      gpr_arr [GPR_NUM];
    addr_t      reg_val;
    resume_t    comb_res;
    resume_t    held;

    for (genvar g = 0; g < GPR_NUM; g++) begin : g_gpr
        assign gpr_arr[g] = gpr_flat[g*ADDR_W +: ADDR_W];
    end

    assign reg_val = gpr_arr[nibs.reg_sel[GPR_IDXW-1:0]];

    resume_decode u_dec (
        .insn (req_insn),
        .kind (kind),
        .nibs (nibs)
    );

    resume_target u_tgt (
        .kind     (kind),
        .nibs     (nibs),
        .pc       (req_pc),
        .cond_t   (cond_t),
        .reg_val  (reg_val),
        .ret_addr (ret_addr),
        .res      (comb_res)
    );

    resume_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (req_valid),
        .d     (comb_res),
        .valid (rsp_valid),
        .q     (held)
    );

    assign rsp_next_pc    = held.next_pc;
    assign rsp_inspect    = held.inspect;
    assign rsp_slot       = held.slot;
    assign rsp_link_we    = held.link_we;
    assign rsp_link_value = held.link_value;

    p_plain_step_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_slot) |-> (rsp_next_pc == rsp_inspect + addr_t'(2)) && !rsp_link_we);
    p_link_after_slot_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_link_we) |-> rsp_slot && (rsp_link_value == rsp_inspect + addr_t'(2)));
    p_link_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !rsp_link_we |-> (rsp_link_value == '0));
endmodule

// File: tb/sim_slot_resume_calc.sv
module sim_slot_resume_calc;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [15:0]  req_insn;
    logic [31:0]  req_pc;
    logic         cond_t;
    logic [511:0] gpr_flat;
    logic [31:0]  ret_addr;
    logic         rsp_valid;
    logic [31:0]  rsp_next_pc;
    logic [31:0]  rsp_inspect;
    logic         rsp_slot;
    logic         rsp_link_we;
    logic [31:0]  rsp_link_value;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    slot_resume_calc u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_insn(req_insn),
        .req_pc(req_pc), .cond_t(cond_t), .gpr_flat(gpr_flat), .ret_addr(ret_addr),
        .rsp_valid(rsp_valid), .rsp_next_pc(rsp_next_pc), .rsp_inspect(rsp_inspect),
        .rsp_slot(rsp_slot), .rsp_link_we(rsp_link_we), .rsp_link_value(rsp_link_value)
    );

    function automatic logic [31:0] gpr_of(input int i);
        return gpr_flat[i*32 +: 32];
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        if (w[15:12] == 4'hA) return "R2";
        if (w[15:12] == 4'hB) return "R3";
        if (w[15:8] == 8'h8D) return "R4";
        if (w[15:8] == 8'h8F) return "R5";
        if (w[15:12] == 4'h4 && w[3:0] == 4'hB && (w[7:4] == 4'h0 || w[7:4] == 4'h2)) return "R6";
        if (w[15:12] == 4'h0 && w[3:0] == 4'h3 && (w[7:4] == 4'h0 || w[7:4] == 4'h2)) return "R7";
        if (w == 16'h000B) return "R8";
        return "R10";
    endfunction

    task automatic expect_of(input logic [15:0] w, input logic [31:0] pc, input logic t,
                             input logic [31:0] pr, output logic [31:0] nx,
                             output logic [31:0] ins, output logic sl,
                             output logic lw, output logic [31:0] lv);
        int d12, d8;
        logic [31:0] rv;
        d12 = (int'(w[11:0]) >= 2048) ? int'(w[11:0]) - 4096 : int'(w[11:0]);
        d8  = (int'(w[7:0]) >= 128) ? int'(w[7:0]) - 256 : int'(w[7:0]);
        rv  = gpr_of(int'(w[11:8]));
        sl = 1'b1; lw = 1'b0; lv = 32'h0; ins = pc + 32'd2;
        case (tag_of(w))
            "R2": nx = pc + 32'd4 + 32'(2 * d12);
            "R3": begin nx = pc + 32'd4 + 32'(2 * d12); lw = 1'b1; lv = pc + 32'd4; end
            "R4": nx = t ? pc + 32'd4 + 32'(2 * d8) : pc + 32'd4;
            "R5": nx = !t ? pc + 32'd4 + 32'(2 * d8) : pc + 32'd4;
            "R6": begin
                nx = rv;
                if (w[7:4] == 4'h0) begin lw = 1'b1; lv = pc + 32'd4; end
            end
            "R7": nx = pc + 32'd4 + rv;
            "R8": nx = pr;
            default: begin nx = pc + 32'd2; ins = pc; sl = 1'b0; end
        endcase
    endtask

    task automatic compare(input string tag, input logic [15:0] w, input logic ev,
                           input logic [31:0] nx, input logic [31:0] ins,
                           input logic sl, input logic lw, input logic [31:0] lv);
        checks++;
        if (rsp_valid !== ev || rsp_next_pc !== nx || rsp_inspect !== ins ||
            rsp_slot !== sl || rsp_link_we !== lw || rsp_link_value !== lv) begin
            errors++;
            $display("FAIL %s insn=%h got v=%b nx=%h ins=%h sl=%b lw=%b lv=%h exp v=%b nx=%h ins=%h sl=%b lw=%b lv=%h",
                     tag, w, rsp_valid, rsp_next_pc, rsp_inspect, rsp_slot, rsp_link_we,
                     rsp_link_value, ev, nx, ins, sl, lw, lv);
        end
    endtask

    task automatic run_one(input logic [15:0] w, input logic [31:0] pc,
                           input logic t, input logic [31:0] pr, input string tag);
        logic [31:0] nx, ins, lv;
        logic sl, lw;
        req_insn = w; req_pc = pc; cond_t = t; ret_addr = pr; req_valid = 1'b1;
        expect_of(w, pc, t, pr, nx, ins, sl, lw, lv);
        @(negedge clk);
        compare(tag, w, 1'b1, nx, ins, sl, lw, lv);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) gpr_flat[i*32 +: 32] = 32'h0101_0000 * (i + 1) + 32'h40 * i;
        rst = 1'b1; req_valid = 1'b0; req_insn = 16'h0; req_pc = 32'h0;
        cond_t = 1'b0; ret_addr = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        compare("R1", 16'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);

        // Exhaustive sweep over opcodes, each tagged by its requirement
        for (int k = 0; k < 65536; k++) begin
            run_one(16'(k), 32'h4000_0000 + 32'(k) * 32'd6, k[4] ^ k[9],
                    32'h0C00_0000 + 32'(k) * 32'd4, tag_of(16'(k)));
        end

        // R4 / R5: both condition polarities on the same opcode
        run_one(16'h8D10, 32'h0000_2000, 1'b1, 32'h0, "R4");
        run_one(16'h8D10, 32'h0000_2000, 1'b0, 32'h0, "R4");
        run_one(16'h8FF0, 32'h0000_2000, 1'b0, 32'h0, "R5");
        run_one(16'h8FF0, 32'h0000_2000, 1'b1, 32'h0, "R5");
        // R2 negative displacement and R3 call link
        run_one(16'hA800, 32'h0001_0000, 1'b0, 32'h0, "R2");
        run_one(16'hBFFF, 32'h0001_0000, 1'b0, 32'h0, "R3");
        // R12: wrap around the top of the address space
        run_one(16'hA001, 32'hFFFF_FFFC, 1'b0, 32'h0, "R12");
        gpr_flat[5*32 +: 32] = 32'hFFFF_FFF0;
        run_one(16'h0523, 32'h0000_0020, 1'b0, 32'h0, "R12");
        // R6 / R7: register-indexed forms with the modified register
        run_one(16'h450B, 32'h0000_0100, 1'b0, 32'h0, "R6");
        run_one(16'h452B, 32'h0000_0100, 1'b0, 32'h0, "R6");
        run_one(16'h0503, 32'h0000_0100, 1'b0, 32'h0, "R7");
        // R10: near misses
        run_one(16'h8B12, 32'h0000_0300, 1'b1, 32'h0, "R10");
        run_one(16'h451B, 32'h0000_0300, 1'b0, 32'h0, "R10");
        run_one(16'h0513, 32'h0000_0300, 1'b0, 32'h0, "R10");
        // R8 return
        run_one(16'h000B, 32'h0000_0400, 1'b0, 32'h1234_5678, "R8");

        // R11: no request -> previous response held, valid low
        begin
            logic [31:0] nx, ins, lv;
            logic sl, lw;
            expect_of(16'hB004, 32'h0000_0800, 1'b0, 32'h0, nx, ins, sl, lw, lv);
            run_one(16'hB004, 32'h0000_0800, 1'b0, 32'h0, "R3");
            req_valid = 1'b0; req_insn = 16'h000B; req_pc = 32'h0BAD_0000; ret_addr = 32'h5555_0000;
            @(negedge clk);
            compare("R11", 16'hB004, 1'b0, nx, ins, sl, lw, lv);
            @(negedge clk);
            compare("R11", 16'hB004, 1'b0, nx, ins, sl, lw, lv);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog got %0d cycles exp fewer", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule